// File: doc/BRIEF.md
# Display Register Window Bridge

This block turns a single memory-mapped window into register traffic for an older display controller. The controller's register file is reached in two ways. One is a set of byte-wide ports at 0x3C0 and up. The other is an index/data pair of 16-bit extension registers. A bus master issues one request of 1, 2 or 4 bytes and holds it until the bridge returns a one-cycle ready pulse. Behind that request the bridge runs the byte-level or index-then-data strobes that the register file expects, and it gathers any read data.

The window has three sub-regions, each with its base as a parameter. The first is a remap of the byte ports. Wide accesses there are cut into ascending byte operations, lowest byte first, so that a single word write can place an index and its data. The second is an extension area, where the register index comes from the address. The third is an optional 32-bit control area with a read-only size word and a framebuffer byte-order flag. That flag changes only when one of two exact magic words is written. Addresses that fall in none of these regions read as zero and have no effect.

Top module: `disp_reg_window`

## Requirements
- R1: After reset, ready_o, port_en_o, ext_idx_wr_o and ext_data_en_o are low and big_endian_o is 0 (little-endian).
- R2: A 1-byte access at byte-port offset N (LEG_BASE+N) makes one port operation at port 0x3C0+N. A read returns that port's byte in rdata_o[7:0] with zero above it.
- R3: A 2-byte write at byte-port offset N makes two port writes: wdata_i[7:0] to port 0x3C0+N first, then wdata_i[15:8] to port 0x3C0+N+1 in the next cycle.
- R4: A 2-byte read at byte-port offset N returns port N in rdata_o[7:0] and port N+1 in rdata_o[15:8].
- R5: A 4-byte byte-port access makes four port operations on consecutive cycles, at ports N to N+3 in ascending order. Byte k of the bus word maps to port N+k.
- R6: An access at offset M of the extension region (EXT_BASE+M) first strobes ext_idx_wr_o with index M>>1. In the next cycle it strobes ext_data_en_o with the 16-bit data wdata_i[15:0]. A read returns ext_rdata_i in rdata_o[15:0].
- R7: In the control region, a 4-byte read at offset 0 returns CTRL_SIZE (default 16). Any other offset except 4 reads 0. A 1- or 2-byte access to the region reads 0 and changes nothing.
- R8: The byte-order word is at control offset 4. Writing BIG_MAGIC (0xBEBEBEBE) sets big_endian_o, and writing LITTLE_MAGIC (0x1E1E1E1E) clears it. Any other value leaves it unchanged. A read returns the magic word of the current mode.
- R9: With CTRL_EN=1, revision_o is 2 and the control region is decoded. With CTRL_EN=0, revision_o is 1 and that range reads as outside.
- R10: An access outside every sub-region reads 0 and strobes nothing toward the register file.
- R11: ready_o is high for exactly one cycle per request. It rises k+1 cycles after acceptance for k byte-port operations, 3 cycles after acceptance for extension accesses, and 1 cycle after acceptance for control or outside accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, held until ready_o |
| we_i | input | 1 | 1 = write |
| addr_i | input | ADDR_W | Byte address in the window |
| size_i | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| wdata_i | input | 32 | Write data, little-endian |
| rdata_o | output | 32 | Read data, valid with ready_o |
| ready_o | output | 1 | One-cycle completion pulse |
| port_en_o | output | 1 | Byte-port operation strobe |
| port_we_o | output | 1 | Byte-port write |
| port_addr_o | output | 16 | Byte-port number |
| port_wdata_o | output | 8 | Byte-port write data |
| port_rdata_i | input | 8 | Byte-port read data, same cycle |
| ext_idx_wr_o | output | 1 | Extension index load strobe |
| ext_idx_o | output | IDX_W | Extension register index |
| ext_data_en_o | output | 1 | Extension data strobe |
| ext_data_we_o | output | 1 | Extension data write |
| ext_wdata_o | output | 16 | Extension write data |
| ext_rdata_i | input | 16 | Extension read data, same cycle |
| big_endian_o | output | 1 | Framebuffer byte-order flag |
| revision_o | output | 8 | Exposed revision identifier |

## Verification
On every cycle, the assertions check several things. The data strobe of an extension access always follows its index strobe. Successive byte-port operations climb one port at a time. At most one register-file strobe is active. The ready pulse lasts one cycle. The byte-order flag holds unless a magic word is written. Only the bench scenarios can show the rest: the exact port numbers and byte lanes, the assembled read words, the index derived from the address, the size and unknown-offset values, the ignored narrow control accesses and the quiet outside accesses. They are checked against expected operations queued per request.

// File: rtl/disp_win_pkg.sv
package disp_win_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEG, ST_EXT_IDX, ST_EXT_DATA, ST_RESP
  } state_e;

  typedef enum logic [1:0] {RG_NONE, RG_LEG, RG_EXT, RG_CTRL} region_e;

  localparam logic [1:0] SZ_1 = 2'd0;
  localparam logic [1:0] SZ_2 = 2'd1;
  localparam logic [1:0] SZ_4 = 2'd2;
endpackage

// File: rtl/win_decode.sv
module win_decode
  import disp_win_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LEG_BASE  = 'h400,
  parameter int LEG_SIZE  = 32,
  parameter int EXT_BASE  = 'h500,
  parameter int EXT_SIZE  = 32,
  parameter int CTRL_BASE = 'h600,
  parameter int CTRL_SIZE = 16,
  parameter bit CTRL_EN   = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [ADDR_W-1:0] offset_o
);
  logic [31:0] a;
  assign a = 32'(addr_i);

  always_comb begin
    region_o = RG_NONE;
    offset_o = '0;
    if (a >= 32'(LEG_BASE) && a < 32'(LEG_BASE + LEG_SIZE)) begin
      region_o = RG_LEG;
      offset_o = ADDR_W'(a - 32'(LEG_BASE));
    end else if (a >= 32'(EXT_BASE) && a < 32'(EXT_BASE + EXT_SIZE)) begin
      region_o = RG_EXT;
      offset_o = ADDR_W'(a - 32'(EXT_BASE));
    end else if (CTRL_EN && a >= 32'(CTRL_BASE) && a < 32'(CTRL_BASE + CTRL_SIZE)) begin
      region_o = RG_CTRL;
      offset_o = ADDR_W'(a - 32'(CTRL_BASE));
    end
  end
endmodule

// File: rtl/byteorder_regs.sv
module byteorder_regs #(
  parameter int          ADDR_W       = 12,
  parameter int          CTRL_SIZE    = 16,
  parameter logic [31:0] BIG_MAGIC    = 32'hBEBE_BEBE,
  parameter logic [31:0] LITTLE_MAGIC = 32'h1E1E_1E1E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              big_endian_o
);
  localparam logic [ADDR_W-1:0] SIZE_OFF  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ORDER_OFF = ADDR_W'(4);

  logic big_q;
  logic order_wr;
  assign order_wr = acc_i && we_i && (off_i == ORDER_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) big_q <= 1'b0;
    else if (order_wr) begin
      if (wdata_i == BIG_MAGIC) big_q <= 1'b1;
      else if (wdata_i == LITTLE_MAGIC) big_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (off_i)
      SIZE_OFF:  rdata_o = 32'(CTRL_SIZE);
      ORDER_OFF: rdata_o = big_q ? BIG_MAGIC : LITTLE_MAGIC;
      default:   rdata_o = '0;
    endcase
  end

  assign big_endian_o = big_q;

  AST_ORDER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(order_wr && (wdata_i == BIG_MAGIC || wdata_i == LITTLE_MAGIC)) |=> $stable(big_q)); // R8
  AST_ORDER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (order_wr && wdata_i == BIG_MAGIC) |=> big_q); // R8
endmodule

// File: rtl/disp_reg_window.sv
module disp_reg_window
  import disp_win_pkg::*;
#(
  parameter int          ADDR_W       = 12,
  parameter int          LEG_BASE     = 'h400,
  parameter int          LEG_SIZE     = 32,
  parameter int          EXT_BASE     = 'h500,
  parameter int          EXT_SIZE     = 32,
  parameter int          CTRL_BASE    = 'h600,
  parameter int          CTRL_SIZE    = 16,
  parameter bit          CTRL_EN      = 1'b1,
  parameter int          PORT_BASE    = 'h3C0,
  parameter logic [31:0] BIG_MAGIC    = 32'hBEBE_BEBE,
  parameter logic [31:0] LITTLE_MAGIC = 32'h1E1E_1E1E,
  parameter int          IDX_W        = $clog2(EXT_SIZE / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ready_o,
  output logic              port_en_o,
  output logic              port_we_o,
  output logic [15:0]       port_addr_o,
  output logic [7:0]        port_wdata_o,
  input  logic [7:0]        port_rdata_i,
  output logic              ext_idx_wr_o,
  output logic [IDX_W-1:0]  ext_idx_o,
  output logic              ext_data_en_o,
  output logic              ext_data_we_o,
  output logic [15:0]       ext_wdata_o,
  input  logic [15:0]       ext_rdata_i,
  output logic              big_endian_o,
  output logic [7:0]        revision_o
);
  state_e            state_q;
  logic              we_q;
  logic [ADDR_W-1:0] off_q;
  logic [31:0]       wdata_q, rdata_q;
  logic [1:0]        cnt_q, last_q;

  region_e           region;
  logic [ADDR_W-1:0] offset;
  logic              ctrl_acc;
  logic [31:0]       ctrl_rdata;
  logic              accept;

  win_decode #(
    .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .LEG_SIZE(LEG_SIZE),
    .EXT_BASE(EXT_BASE), .EXT_SIZE(EXT_SIZE),
    .CTRL_BASE(CTRL_BASE), .CTRL_SIZE(CTRL_SIZE), .CTRL_EN(CTRL_EN)
  ) u_decode (
    .addr_i(addr_i), .region_o(region), .offset_o(offset)
  );

  assign accept   = (state_q == ST_IDLE) && req_i;
  assign ctrl_acc = accept && (region == RG_CTRL) && (size_i == SZ_4);

  byteorder_regs #(
    .ADDR_W(ADDR_W), .CTRL_SIZE(CTRL_SIZE),
    .BIG_MAGIC(BIG_MAGIC), .LITTLE_MAGIC(LITTLE_MAGIC)
  ) u_order (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(ctrl_acc), .we_i(we_i),
    .off_i(offset), .wdata_i(wdata_i), .rdata_o(ctrl_rdata),
    .big_endian_o(big_endian_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      off_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cnt_q   <= '0;
      last_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          we_q    <= we_i;
          off_q   <= offset;
          wdata_q <= wdata_i;
          rdata_q <= '0;
          cnt_q   <= '0;
          last_q  <= (size_i == SZ_1) ? 2'd0 : (size_i == SZ_2) ? 2'd1 : 2'd3;
          unique case (region)
            RG_LEG:  state_q <= ST_LEG;
            RG_EXT:  state_q <= ST_EXT_IDX;
            RG_CTRL: begin
              rdata_q <= (size_i == SZ_4 && !we_i) ? ctrl_rdata : '0;
              state_q <= ST_RESP;
            end
            default: state_q <= ST_RESP;
          endcase
        end
        ST_LEG: begin
          // byte lanes ascend so an index byte lands before its data byte
          if (!we_q) rdata_q[8*cnt_q +: 8] <= port_rdata_i;
          if (cnt_q == last_q) state_q <= ST_RESP;
          else cnt_q <= cnt_q + 2'd1;
        end
        ST_EXT_IDX: state_q <= ST_EXT_DATA;
        ST_EXT_DATA: begin
          if (!we_q) rdata_q <= {16'h0, ext_rdata_i};
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o       = (state_q == ST_RESP);
  assign rdata_o       = ready_o ? rdata_q : '0;
  assign port_en_o     = (state_q == ST_LEG);
  assign port_we_o     = port_en_o && we_q;
  assign port_addr_o   = 16'(PORT_BASE) + 16'(off_q) + 16'(cnt_q);
  assign port_wdata_o  = wdata_q[8*cnt_q +: 8];
  assign ext_idx_wr_o  = (state_q == ST_EXT_IDX);
  assign ext_idx_o     = off_q[IDX_W:1];
  assign ext_data_en_o = (state_q == ST_EXT_DATA);
  assign ext_data_we_o = ext_data_en_o && we_q;
  assign ext_wdata_o   = wdata_q[15:0];
  assign revision_o    = CTRL_EN ? 8'd2 : 8'd1;

  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R11
  AST_EXT_IDX_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_data_en_o |-> $past(ext_idx_wr_o)); // R6
  AST_PORT_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_en_o && $past(port_en_o)) |-> (port_addr_o == $past(port_addr_o) + 16'd1)); // R3
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({port_en_o, ext_idx_wr_o, ext_data_en_o})); // R10
  AST_IDX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_data_en_o |-> $stable(ext_idx_o)); // R6
endmodule

// File: tb/disp_reg_window_tb.sv
module disp_reg_window_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic        ready_o, port_en_o, port_we_o;
  logic [15:0] port_addr_o;
  logic [7:0]  port_wdata_o, port_rdata;
  logic        ext_idx_wr_o, ext_data_en_o, ext_data_we_o;
  logic [3:0]  ext_idx_o;
  logic [15:0] ext_wdata_o, ext_rdata;
  logic        big_endian_o;
  logic [7:0]  revision_o;

  int vectors = 0, fails = 0;
  logic [35:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  assign port_rdata = port_addr_o[7:0] ^ 8'h5A;
  assign ext_rdata  = 16'hC0DE ^ {12'h0, ext_idx_o};

  disp_reg_window u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata_o), .ready_o(ready_o),
    .port_en_o(port_en_o), .port_we_o(port_we_o), .port_addr_o(port_addr_o),
    .port_wdata_o(port_wdata_o), .port_rdata_i(port_rdata),
    .ext_idx_wr_o(ext_idx_wr_o), .ext_idx_o(ext_idx_o),
    .ext_data_en_o(ext_data_en_o), .ext_data_we_o(ext_data_we_o),
    .ext_wdata_o(ext_wdata_o), .ext_rdata_i(ext_rdata),
    .big_endian_o(big_endian_o), .revision_o(revision_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind: 1 port op, 2 index load, 3 data op
  task automatic push_op(input logic [1:0] kind, input logic w, input logic [15:0] a,
                         input logic [15:0] d, input string tag);
    exp_q.push_back({kind, w, a, (w ? d : 16'h0)});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && (port_en_o || ext_idx_wr_o || ext_data_en_o)) begin
      logic [35:0] act;
      if (port_en_o)         act = {2'd1, port_we_o, port_addr_o, (port_we_o ? {8'h0, port_wdata_o} : 16'h0)};
      else if (ext_idx_wr_o) act = {2'd2, 1'b0, 12'h0, ext_idx_o, 16'h0};
      else                   act = {2'd3, ext_data_we_o, 12'h0, ext_idx_o, (ext_data_we_o ? ext_wdata_o : 16'h0)};
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected strobe actual=%h expected=none", act);
      end else begin
        logic [35:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          fails++;
          $display("FAIL %s op actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  task automatic access(input logic w, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input logic chk, input logic [31:0] exp_rd,
                        input int exp_lat, input string tag);
    int lat = 0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = sz; wdata = d;
    do begin
      @(negedge clk);
      lat++;
    end while (!ready_o && lat < 50);
    if (chk) check({tag, " rdata"}, rdata_o, exp_rd);
    check("R11 latency", 32'(lat), 32'(exp_lat));
    check({tag, " ops drained"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
    tag_q.delete();
    req = 1'b0;
    @(negedge clk);
    check("R11 ready single", 32'(ready_o), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready", 32'(ready_o), 0);
    check("R1 strobes", 32'({port_en_o, ext_idx_wr_o, ext_data_en_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 big_endian", 32'(big_endian_o), 0);
    check("R9 revision", 32'(revision_o), 2);

    // R2 byte read and byte write
    push_op(1, 0, 16'h3C4, 0, "R2");
    access(0, 12'h404, 2'd0, 0, 1, 32'h0000_009E, 2, "R2");
    push_op(1, 1, 16'h3D4, 16'h00AB, "R2");
    access(1, 12'h414, 2'd0, 32'h0000_00AB, 0, 0, 2, "R2");
    // R3 word write: low byte first
    push_op(1, 1, 16'h3C4, 16'h0011, "R3");
    push_op(1, 1, 16'h3C5, 16'h000A, "R3");
    access(1, 12'h404, 2'd1, 32'h0000_0A11, 0, 0, 3, "R3");
    // R4 word read
    push_op(1, 0, 16'h3D0, 0, "R4");
    push_op(1, 0, 16'h3D1, 0, "R4");
    access(0, 12'h410, 2'd1, 0, 1, 32'h0000_8B8A, 3, "R4");
    // R5 dword write and read
    push_op(1, 1, 16'h3C8, 16'h00AA, "R5");
    push_op(1, 1, 16'h3C9, 16'h00BB, "R5");
    push_op(1, 1, 16'h3CA, 16'h00CC, "R5");
    push_op(1, 1, 16'h3CB, 16'h00DD, "R5");
    access(1, 12'h408, 2'd2, 32'hDDCC_BBAA, 0, 0, 5, "R5");
    for (int k = 0; k < 4; k++) push_op(1, 0, 16'h3C0 + 16'(k), 0, "R5");
    access(0, 12'h400, 2'd2, 0, 1, 32'h9998_9B9A, 5, "R5");
    // R6 extension write and read
    push_op(2, 0, 16'h0004, 0, "R6");
    push_op(3, 1, 16'h0004, 16'h0320, "R6");
    access(1, 12'h508, 2'd1, 32'h0000_0320, 0, 0, 3, "R6");
    push_op(2, 0, 16'h0005, 0, "R6");
    push_op(3, 0, 16'h0005, 0, "R6");
    access(0, 12'h50A, 2'd1, 0, 1, 32'h0000_C0DB, 3, "R6");
    // R7 control size, unknown offset, narrow access
    access(0, 12'h600, 2'd2, 0, 1, 32'd16, 1, "R7");
    access(0, 12'h608, 2'd2, 0, 1, 32'd0, 1, "R7");
    access(0, 12'h600, 2'd1, 0, 1, 32'd0, 1, "R7");
    // R8 byte-order magic words
    access(0, 12'h604, 2'd2, 0, 1, 32'h1E1E_1E1E, 1, "R8");
    access(1, 12'h604, 2'd2, 32'hBEBE_BEBE, 0, 0, 1, "R8");
    check("R8 set", 32'(big_endian_o), 1);
    access(1, 12'h604, 2'd2, 32'h1234_5678, 0, 0, 1, "R8");
    access(0, 12'h604, 2'd2, 0, 1, 32'hBEBE_BEBE, 1, "R8");
    access(1, 12'h604, 2'd2, 32'h1E1E_1E1E, 0, 0, 1, "R8");
    check("R8 clear", 32'(big_endian_o), 0);
    access(1, 12'h604, 2'd0, 32'hBEBE_BEBE, 0, 0, 1, "R7");
    check("R7 narrow write ignored", 32'(big_endian_o), 0);
    // R10 outside the window
    access(1, 12'h700, 2'd2, 32'hFFFF_FFFF, 0, 0, 1, "R10");
    access(0, 12'h000, 2'd2, 0, 1, 32'd0, 1, "R10");
    check("R10 order untouched", 32'(big_endian_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule